// File: doc/BRIEF.md
# Exception Entry Controller

This block makes the entry decision a processor core needs when it takes a general exception or a debug exception. On a general exception request it selects one of three vectors: kernel, user or double-fault. It saves the faulting PC into the right return slot, records the cause code and, when one is supplied, the faulting address. It also produces the new status word with the exception-active flag set. On a debug request it first checks the current interrupt level against a configured debug level. If the request is accepted, it saves the PC and the old status word into the slots for that level, records the debug cause, and raises the interrupt level.

The core presents its current status word on `cur_ps` and takes the updated word from `ps_out` whenever `vec_valid` pulses. All saved registers live inside the block and are visible on output buses. A request is sampled on one rising edge. The vector strobe and every register update appear together on that same edge and last one clock.

The control is a two-state machine:
- ST_IDLE: the normal state.
- ST_DBG_HOLD: a debug request arrived in the same cycle as a general exception and is waiting.

Transitions:
- ST_IDLE to ST_DBG_HOLD: a general and a debug request arrive together.
- ST_DBG_HOLD to ST_DBG_HOLD: further general requests keep arriving.
- ST_DBG_HOLD to ST_IDLE: the first cycle with no general request. The held debug request is then taken or dropped.
- ST_IDLE to ST_IDLE: every other case.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `vec_valid` is 0, `vec_code` is 0 and every saved register and `ps_out` is 0.
- R2: A general request with the exception-active flag (status bit 4) clear and the user-mode flag (status bit 5) clear gives vector code 1 (kernel) and saves the PC in the level-1 return slot (`ret_pc_bus` bits PC_W-1:0).
- R3: A general request with status bit 4 clear and bit 5 set gives vector code 2 (user) and saves the PC in the level-1 return slot.
- R4: A general request with status bit 4 set gives vector code 3 (double fault). With the double-fault slot configured (HAS_DBL_SLOT=1), the PC goes to `dbl_ret_pc` and the level-1 slot is unchanged.
- R5: With HAS_DBL_SLOT=0, a double fault saves the PC in the level-1 slot and `dbl_ret_pc` stays 0.
- R6: Every general exception writes the cause to `cause_out` and sets `ps_out` to `cur_ps` with bit 4 set and all other bits kept.
- R7: When `exc_va_vld` is 1, `fault_addr` receives `exc_va`. When it is 0, `fault_addr` keeps its value.
- R8: A debug request is ignored when the interrupt-level field (status bits 3:0) is not below DBG_LEVEL. An ignored request produces no strobe and leaves every output unchanged.
- R9: An accepted debug request gives vector code 4. It writes `dbg_cause_out`, stores the PC in return slot DBG_LEVEL and the old status word in saved-status slot DBG_LEVEL (`saved_ps_bus` index DBG_LEVEL-2). It sets `ps_out` to `cur_ps` with bits 3:0 replaced by DBG_LEVEL and bit 4 set.
- R10: When a debug and a general request arrive together, the general one is taken. The debug request, with its cause and PC, is held until the first cycle without a general request. In that cycle it is accepted or dropped using the `cur_ps` of that cycle, and new debug requests in that cycle are discarded.
- R11: `vec_valid` is 1 for exactly the one clock after each accepted request, and 0 otherwise. All register updates appear on the same edge as the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | General exception request |
| exc_cause | input | CAUSE_W | Exception cause code |
| exc_pc | input | PC_W | PC of the faulting instruction |
| exc_va_vld | input | 1 | Faulting address present |
| exc_va | input | PC_W | Faulting virtual address |
| dbg_req | input | 1 | Debug exception request |
| dbg_cause | input | DCAUSE_W | Debug cause |
| dbg_pc | input | PC_W | PC for the debug exception |
| cur_ps | input | PS_W | Current status word |
| vec_valid | output | 1 | One-clock vector strobe |
| vec_code | output | 3 | 0 none, 1 kernel, 2 user, 3 double fault, 4 debug |
| ps_out | output | PS_W | Updated status word |
| ret_pc_bus | output | DBG_LEVEL*PC_W | Return PC slots; level L at slice L-1 |
| saved_ps_bus | output | (DBG_LEVEL-1)*PS_W | Saved status slots for levels 2..DBG_LEVEL |
| dbl_ret_pc | output | PC_W | Double-fault return PC |
| cause_out | output | CAUSE_W | Last general cause |
| fault_addr | output | PC_W | Last faulting address |
| dbg_cause_out | output | DCAUSE_W | Last debug cause |

## Verification
Single general requests are applied under each combination of the exception-active and user-mode flags. This separates the kernel, user and double-fault choices and shows which return slot each one writes. A second instance without the double-fault slot receives the same stimulus, so the double-fault choice is seen in both configurations. Debug requests are applied with interrupt levels just below, at and above the debug level, which locates the acceptance boundary. Collisions with one or several following general requests, resolved at both an allowed and a blocked level, check that the held request is neither lost nor taken twice. A long run of random requests then checks that every field stays correct across mixed traffic.

// File: rtl/excn_pkg.sv
package excn_pkg;

    typedef enum logic [2:0] {
        VEC_NONE   = 3'd0,
        VEC_KERNEL = 3'd1,
        VEC_USER   = 3'd2,
        VEC_DOUBLE = 3'd3,
        VEC_DEBUG  = 3'd4
    } vec_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_DBG_HOLD = 1'b1
    } st_e;

endpackage

// File: rtl/excn_classify.sv
module excn_classify
    import excn_pkg::*;
#(
    parameter int PS_W         = 8,
    parameter int ACT_BIT      = 4,
    parameter int USER_BIT     = 5,
    parameter int HAS_DBL_SLOT = 1
) (
    input  logic [PS_W-1:0] cur_ps,
    output vec_e            vec,
    output logic            dbl_slot,
    output logic [PS_W-1:0] ps_next
);
    localparam logic [PS_W-1:0] ACT_MASK = PS_W'(1) << ACT_BIT;

    logic in_exc;

    always_comb begin
        in_exc   = cur_ps[ACT_BIT];
        if (in_exc) begin
            vec = VEC_DOUBLE;
        end else if (cur_ps[USER_BIT]) begin
            vec = VEC_USER;
        end else begin
            vec = VEC_KERNEL;
        end
        dbl_slot = in_exc && (HAS_DBL_SLOT != 0);
        ps_next  = cur_ps | ACT_MASK;
    end

endmodule

// File: rtl/excn_dbg_gate.sv
module excn_dbg_gate #(
    parameter int PS_W      = 8,
    parameter int ILVL_LSB  = 0,
    parameter int ILVL_W    = 4,
    parameter int ACT_BIT   = 4,
    parameter int DBG_LEVEL = 6
) (
    input  logic [PS_W-1:0] cur_ps,
    output logic            allow,
    output logic [PS_W-1:0] ps_next
);
    localparam logic [PS_W-1:0] LVL_MASK = PS_W'((1 << ILVL_W) - 1) << ILVL_LSB;
    localparam logic [PS_W-1:0] LVL_VAL  = PS_W'(DBG_LEVEL) << ILVL_LSB;
    localparam logic [PS_W-1:0] ACT_MASK = PS_W'(1) << ACT_BIT;

    logic [ILVL_W-1:0] lvl;

    always_comb begin
        lvl     = cur_ps[ILVL_LSB +: ILVL_W];
        allow   = lvl < ILVL_W'(DBG_LEVEL);
        ps_next = (cur_ps & ~LVL_MASK) | LVL_VAL | ACT_MASK;
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import excn_pkg::*;
#(
    parameter int PC_W         = 32,
    parameter int CAUSE_W      = 6,
    parameter int DCAUSE_W     = 6,
    parameter int PS_W         = 8,
    parameter int ILVL_LSB     = 0,
    parameter int ILVL_W       = 4,
    parameter int ACT_BIT      = 4,
    parameter int USER_BIT     = 5,
    parameter int DBG_LEVEL    = 6,
    parameter int HAS_DBL_SLOT = 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            exc_req,
    input  logic [CAUSE_W-1:0]              exc_cause,
    input  logic [PC_W-1:0]                 exc_pc,
    input  logic                            exc_va_vld,
    input  logic [PC_W-1:0]                 exc_va,
    input  logic                            dbg_req,
    input  logic [DCAUSE_W-1:0]             dbg_cause,
    input  logic [PC_W-1:0]                 dbg_pc,
    input  logic [PS_W-1:0]                 cur_ps,
    output logic                            vec_valid,
    output logic [2:0]                      vec_code,
    output logic [PS_W-1:0]                 ps_out,
    output logic [DBG_LEVEL*PC_W-1:0]       ret_pc_bus,
    output logic [(DBG_LEVEL-1)*PS_W-1:0]   saved_ps_bus,
    output logic [PC_W-1:0]                 dbl_ret_pc,
    output logic [CAUSE_W-1:0]              cause_out,
    output logic [PC_W-1:0]                 fault_addr,
    output logic [DCAUSE_W-1:0]             dbg_cause_out
);
    st_e                 st_q, st_d;
    logic [DCAUSE_W-1:0] pend_cause_q;
    logic [PC_W-1:0]     pend_pc_q;

    vec_e                cls_vec;
    logic                cls_dbl_slot;
    logic [PS_W-1:0]     cls_ps;
    logic                dbg_ok;
    logic [PS_W-1:0]     dbg_ps;

    logic                dbg_cand;
    logic [DCAUSE_W-1:0] dbg_cause_sel;
    logic [PC_W-1:0]     dbg_pc_sel;
    logic                take_exc;
    logic                take_dbg;

    vec_e                vec_q;

    excn_classify #(
        .PS_W(PS_W), .ACT_BIT(ACT_BIT), .USER_BIT(USER_BIT), .HAS_DBL_SLOT(HAS_DBL_SLOT)
    ) u_classify (
        .cur_ps(cur_ps), .vec(cls_vec), .dbl_slot(cls_dbl_slot), .ps_next(cls_ps)
    );

    excn_dbg_gate #(
        .PS_W(PS_W), .ILVL_LSB(ILVL_LSB), .ILVL_W(ILVL_W),
        .ACT_BIT(ACT_BIT), .DBG_LEVEL(DBG_LEVEL)
    ) u_dbg_gate (
        .cur_ps(cur_ps), .allow(dbg_ok), .ps_next(dbg_ps)
    );

    // Debug candidate: the live request when idle, the held one when waiting
    always_comb begin
        dbg_cand      = 1'b0;
        dbg_cause_sel = dbg_cause;
        dbg_pc_sel    = dbg_pc;
        unique case (st_q)
            ST_IDLE: dbg_cand = dbg_req;
            ST_DBG_HOLD: begin
                dbg_cand      = 1'b1;
                dbg_cause_sel = pend_cause_q;
                dbg_pc_sel    = pend_pc_q;
            end
            default: ;
        endcase
    end

    assign take_exc = exc_req;
    assign take_dbg = !exc_req && dbg_cand && dbg_ok;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (exc_req && dbg_req) st_d = ST_DBG_HOLD;
            ST_DBG_HOLD: if (!exc_req) st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Held debug request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_cause_q <= '0;
            pend_pc_q    <= '0;
        end else if (st_q == ST_IDLE && exc_req && dbg_req) begin
            pend_cause_q <= dbg_cause;
            pend_pc_q    <= dbg_pc;
        end
    end

    // Outputs: strobe, vector, status word and cause records
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_valid     <= 1'b0;
            vec_q         <= VEC_NONE;
            ps_out        <= '0;
            cause_out     <= '0;
            fault_addr    <= '0;
            dbg_cause_out <= '0;
        end else begin
            vec_valid <= take_exc || take_dbg;
            if (take_exc) begin
                vec_q     <= cls_vec;
                ps_out    <= cls_ps;
                cause_out <= exc_cause;
                if (exc_va_vld) begin
                    fault_addr <= exc_va;
                end
            end else if (take_dbg) begin
                vec_q         <= VEC_DEBUG;
                ps_out        <= dbg_ps;
                dbg_cause_out <= dbg_cause_sel;
            end else begin
                vec_q <= VEC_NONE;
            end
        end
    end

    assign vec_code = vec_q;

    // Return PC slots: level 1 for general entries, DBG_LEVEL for debug entry
    for (genvar lv = 1; lv <= DBG_LEVEL; lv++) begin : g_ret
        if (lv == 1) begin : g_exc
            logic [PC_W-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r <= '0;
                end else if (take_exc && !cls_dbl_slot) begin
                    r <= exc_pc;
                end
            end
            assign ret_pc_bus[(lv-1)*PC_W +: PC_W] = r;
        end else if (lv == DBG_LEVEL) begin : g_dbg
            logic [PC_W-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r <= '0;
                end else if (take_dbg) begin
                    r <= dbg_pc_sel;
                end
            end
            assign ret_pc_bus[(lv-1)*PC_W +: PC_W] = r;
        end else begin : g_none
            assign ret_pc_bus[(lv-1)*PC_W +: PC_W] = '0;
        end
    end

    // Saved status slots for levels 2..DBG_LEVEL
    for (genvar lv = 2; lv <= DBG_LEVEL; lv++) begin : g_sps
        if (lv == DBG_LEVEL) begin : g_dbg
            logic [PS_W-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r <= '0;
                end else if (take_dbg) begin
                    r <= cur_ps;
                end
            end
            assign saved_ps_bus[(lv-2)*PS_W +: PS_W] = r;
        end else begin : g_none
            assign saved_ps_bus[(lv-2)*PS_W +: PS_W] = '0;
        end
    end

    if (HAS_DBL_SLOT != 0) begin : g_dbl
        logic [PC_W-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r <= '0;
            end else if (take_exc && cls_dbl_slot) begin
                r <= exc_pc;
            end
        end
        assign dbl_ret_pc = r;
    end else begin : g_no_dbl
        assign dbl_ret_pc = '0;
    end

    // Checks
    assert_exc_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> vec_valid);

    assert_cause_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> (cause_out == $past(exc_cause)) && ps_out[ACT_BIT]);

    assert_double_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && cur_ps[ACT_BIT]) |=> (vec_code == VEC_DOUBLE));

    assert_dbg_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !exc_req && dbg_req &&
         cur_ps[ILVL_LSB +: ILVL_W] >= ILVL_W'(DBG_LEVEL)) |=> !vec_valid);

    assert_dbg_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_code == VEC_DEBUG) |-> (ps_out[ILVL_LSB +: ILVL_W] == ILVL_W'(DBG_LEVEL)));

    assert_hold_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DBG_HOLD && !exc_req) |=> (st_q == ST_IDLE));

endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
    localparam int PW = 32;
    localparam int CW = 6;
    localparam int DW = 6;
    localparam int SW = 8;
    localparam int DL = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exc_req = 1'b0;
    logic [CW-1:0] exc_cause = '0;
    logic [PW-1:0] exc_pc = '0;
    logic exc_va_vld = 1'b0;
    logic [PW-1:0] exc_va = '0;
    logic dbg_req = 1'b0;
    logic [DW-1:0] dbg_cause = '0;
    logic [PW-1:0] dbg_pc = '0;
    logic [SW-1:0] cur_ps = '0;

    logic vec_valid, nd_valid;
    logic [2:0] vec_code, nd_code;
    logic [SW-1:0] ps_out, nd_ps;
    logic [DL*PW-1:0] ret_pc_bus, nd_ret;
    logic [(DL-1)*SW-1:0] saved_ps_bus, nd_sps;
    logic [PW-1:0] dbl_ret_pc, nd_dbl, fault_addr, nd_fa;
    logic [CW-1:0] cause_out, nd_cause;
    logic [DW-1:0] dbg_cause_out, nd_dcause;

    always #5 clk = ~clk;

    exc_entry_ctrl #(.DBG_LEVEL(DL), .HAS_DBL_SLOT(1)) dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
        .exc_pc(exc_pc), .exc_va_vld(exc_va_vld), .exc_va(exc_va),
        .dbg_req(dbg_req), .dbg_cause(dbg_cause), .dbg_pc(dbg_pc), .cur_ps(cur_ps),
        .vec_valid(vec_valid), .vec_code(vec_code), .ps_out(ps_out),
        .ret_pc_bus(ret_pc_bus), .saved_ps_bus(saved_ps_bus), .dbl_ret_pc(dbl_ret_pc),
        .cause_out(cause_out), .fault_addr(fault_addr), .dbg_cause_out(dbg_cause_out));

    exc_entry_ctrl #(.DBG_LEVEL(DL), .HAS_DBL_SLOT(0)) dut_nd (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
        .exc_pc(exc_pc), .exc_va_vld(exc_va_vld), .exc_va(exc_va),
        .dbg_req(dbg_req), .dbg_cause(dbg_cause), .dbg_pc(dbg_pc), .cur_ps(cur_ps),
        .vec_valid(nd_valid), .vec_code(nd_code), .ps_out(nd_ps),
        .ret_pc_bus(nd_ret), .saved_ps_bus(nd_sps), .dbl_ret_pc(nd_dbl),
        .cause_out(nd_cause), .fault_addr(nd_fa), .dbg_cause_out(nd_dcause));

    // Behavioural reference
    logic m_vv;
    logic [2:0] m_code;
    logic [SW-1:0] m_ps;
    logic [PW-1:0] m_ret [1:DL];
    logic [SW-1:0] m_sps [2:DL];
    logic [PW-1:0] m_dbl, m_nd_ret1, m_va;
    logic [CW-1:0] m_cause;
    logic [DW-1:0] m_dcause;
    logic m_pend;
    logic [DW-1:0] m_pcause;
    logic [PW-1:0] m_ppc;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_vv = 0; m_code = 0; m_ps = 0; m_dbl = 0; m_nd_ret1 = 0; m_va = 0;
            m_cause = 0; m_dcause = 0; m_pend = 0; m_pcause = 0; m_ppc = 0;
            for (int i = 1; i <= DL; i++) m_ret[i] = 0;
            for (int i = 2; i <= DL; i++) m_sps[i] = 0;
        end else begin
            m_vv = 0; m_code = 0;
            if (exc_req) begin
                if (cur_ps[4]) begin
                    m_code = 3; m_dbl = exc_pc;
                end else begin
                    m_code = cur_ps[5] ? 3'd2 : 3'd1; m_ret[1] = exc_pc;
                end
                m_nd_ret1 = exc_pc;
                m_cause = exc_cause;
                if (exc_va_vld) m_va = exc_va;
                m_ps = cur_ps | 8'h10;
                m_vv = 1;
                if (dbg_req && !m_pend) begin
                    m_pend = 1; m_pcause = dbg_cause; m_ppc = dbg_pc;
                end
            end else begin
                logic dt;
                logic [DW-1:0] dc;
                logic [PW-1:0] dp;
                dt = 0; dc = 0; dp = 0;
                if (m_pend) begin
                    m_pend = 0; dt = 1; dc = m_pcause; dp = m_ppc;
                end else if (dbg_req) begin
                    dt = 1; dc = dbg_cause; dp = dbg_pc;
                end
                if (dt && int'(cur_ps[3:0]) < DL) begin
                    m_vv = 1; m_code = 4; m_dcause = dc; m_ret[DL] = dp;
                    m_sps[DL] = cur_ps;
                    m_ps = (cur_ps & 8'hF0) | 8'(DL) | 8'h10;
                end
            end
        end
    end

    int checks = 0;
    int fails = 0;
    string tag = "R1";

    task automatic cmp(input string f, input logic [PW-1:0] act, input logic [PW-1:0] exp, inout bit bad);
        if (act !== exp) begin
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, f, act, exp, $time);
            bad = 1;
        end
    endtask

    // Compare every clock, at the falling edge
    always @(negedge clk) begin
        if ($time > 6) begin
            bit bad;
            bad = 0;
            checks++;
            cmp("vec_valid", PW'(vec_valid), PW'(m_vv), bad);
            cmp("vec_code", PW'(vec_code), PW'(m_code), bad);
            cmp("ps_out", PW'(ps_out), PW'(m_ps), bad);
            for (int i = 1; i <= DL; i++)
                cmp("ret_pc", ret_pc_bus[(i-1)*PW +: PW], m_ret[i], bad);
            for (int i = 2; i <= DL; i++)
                cmp("saved_ps", PW'(saved_ps_bus[(i-2)*SW +: SW]), PW'(m_sps[i]), bad);
            cmp("dbl_ret_pc", dbl_ret_pc, m_dbl, bad);
            cmp("cause_out", PW'(cause_out), PW'(m_cause), bad);
            cmp("fault_addr", fault_addr, m_va, bad);
            cmp("dbg_cause_out", PW'(dbg_cause_out), PW'(m_dcause), bad);
            // R5: variant without the double-fault slot
            cmp("R5 nd_ret1", nd_ret[PW-1:0], m_nd_ret1, bad);
            cmp("R5 nd_dbl", nd_dbl, '0, bad);
            if (bad) fails++;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            exc_req = 0; dbg_req = 0; exc_va_vld = 0;
        end
    endtask

    task automatic exc(input logic [CW-1:0] c, input logic [PW-1:0] pc, input logic v,
                       input logic [PW-1:0] va, input logic [SW-1:0] ps);
        @(negedge clk); #1;
        exc_req = 1; exc_cause = c; exc_pc = pc; exc_va_vld = v; exc_va = va;
        dbg_req = 0; cur_ps = ps;
    endtask

    task automatic dbg(input logic [DW-1:0] c, input logic [PW-1:0] pc, input logic [SW-1:0] ps);
        @(negedge clk); #1;
        exc_req = 0; exc_va_vld = 0; dbg_req = 1; dbg_cause = c; dbg_pc = pc; cur_ps = ps;
    endtask

    task automatic both(input logic [CW-1:0] c, input logic [PW-1:0] pc,
                        input logic [DW-1:0] dc, input logic [PW-1:0] dpc, input logic [SW-1:0] ps);
        @(negedge clk); #1;
        exc_req = 1; exc_cause = c; exc_pc = pc; exc_va_vld = 0;
        dbg_req = 1; dbg_cause = dc; dbg_pc = dpc; cur_ps = ps;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        idle(2);
        tag = "R2";  exc(6'd5, 32'h0000_1000, 0, 0, 8'h00); idle(1);
        tag = "R3";  exc(6'd9, 32'h0000_2000, 0, 0, 8'h22); idle(1);
        tag = "R7";  exc(6'd3, 32'h0000_3000, 1, 32'hDEAD_BEE0, 8'h01); idle(1);
        exc(6'd4, 32'h0000_3100, 0, 32'h1111_1111, 8'h01); idle(1);
        tag = "R4";  exc(6'd7, 32'h0000_4000, 0, 0, 8'h10); idle(1);
        exc(6'd8, 32'h0000_4100, 1, 32'h0BAD_0000, 8'h35); idle(1);
        tag = "R6";  exc(6'd63, 32'hFFFF_FFFC, 0, 0, 8'hCF); idle(1);
        tag = "R8";  dbg(6'd1, 32'h0000_5000, 8'h06); idle(1);
        dbg(6'd2, 32'h0000_5100, 8'h0F); idle(1);
        tag = "R9";  dbg(6'd3, 32'h0000_6000, 8'h05); idle(1);
        dbg(6'd4, 32'h0000_6100, 8'hA0); idle(1);
        tag = "R10"; both(6'd11, 32'h0000_7000, 6'd21, 32'h0000_7100, 8'h00);
        @(negedge clk); #1; exc_req = 0; dbg_req = 1; dbg_cause = 6'd30; cur_ps = 8'h12;
        idle(2);
        both(6'd12, 32'h0000_7200, 6'd22, 32'h0000_7300, 8'h01);
        exc(6'd13, 32'h0000_7400, 0, 0, 8'h11);
        exc(6'd14, 32'h0000_7500, 0, 0, 8'h11);
        @(negedge clk); #1; exc_req = 0; cur_ps = 8'h13;
        idle(2);
        both(6'd15, 32'h0000_7600, 6'd23, 32'h0000_7700, 8'h00);
        @(negedge clk); #1; exc_req = 0; dbg_req = 0; cur_ps = 8'h17;
        idle(2);
        tag = "R11"; exc(6'd1, 32'h0000_8000, 0, 0, 8'h00);
        exc(6'd2, 32'h0000_8004, 0, 0, 8'h10);
        dbg(6'd5, 32'h0000_8008, 8'h00);
        idle(3);
        tag = "R6";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk); #1;
            exc_req = ($urandom % 3) == 0;
            exc_cause = CW'($urandom);
            exc_pc = $urandom;
            exc_va_vld = $urandom % 2;
            exc_va = $urandom;
            dbg_req = ($urandom % 3) == 0;
            dbg_cause = DW'($urandom);
            dbg_pc = $urandom;
            cur_ps = SW'($urandom);
        end
        idle(3);
        finish_run();
    end
endmodule